// File: doc/BRIEF.md
# Strided Two-Axis Address Walker

This block turns one decoded two-dimensional copy command into a paced stream of element addresses. Each element of the stream carries a source address, a destination address and the byte size of the element on each side. Each side of the command has its own 64-bit start address, an x and a y stride (signed, counted in elements), an x and a y element count, and an element size in bytes. The x axis is walked fastest. Because the strides are signed, either axis of either side can be traversed backwards.

Each side also carries an 8-bit limit-check control byte. When the check is enabled, every address on that side is compared against a limit taken from a bank of 32-bit limit registers. An address above the limit either aborts the command with an error pulse or is silently dropped, depending on a notification flag in the control byte. The command ends with a one-cycle done pulse, or with a one-cycle error pulse that also says which side caused it.

Top module: `stride2d_addr_gen`

## Requirements
- R1: After reset the block is idle: `cmd_ready_o`=1, and `out_valid_o`, `done_o` and `err_o` are all 0.
- R2: Element k of the stream uses ix = k mod count_x and iy = k div count_x on each side independently, so x is walked fastest. Its address is start + (ix*step_x + iy*step_y)*elem_size, computed with 64-bit wraparound and with the steps taken as signed 32-bit values.
- R3: A negative step walks its axis toward lower addresses.
- R4: If any count on either side is zero, `done_o` pulses in the cycle after the command is accepted and no element is emitted.
- R5: The stream length is the smaller of the two sides' element totals (count_x*count_y). `done_o` pulses in the cycle after the last element handshake.
- R6: While `out_valid_o`=1 and `out_ready_i`=0, the valid flag and both addresses hold steady into the next cycle.
- R7: Control byte layout: bits [5:0] register index, bit 6 suppresses notification, bit 7 enables the check. When the check is enabled, an address passes only if it is less than or equal to the limit (unsigned compare). An address equal to the limit passes. Without wide mode, the limit is register[index] zero-extended to 64 bits.
- R8: With `wide_i`=1 at acceptance, the upper 32 bits of the limit come from register[(index+1) mod 64]. Limits are captured when the command is accepted.
- R9: A failing address on a side whose bit 6 is 0 produces a one-cycle `err_o` pulse. That element and all later elements are not emitted, `done_o` does not pulse, and the block returns to idle.
- R10: A failing address on a side whose bit 6 is 1 is dropped without being emitted, and the walk continues to `done_o`.
- R11: The source side is checked before the destination side. `err_src_o` is 1 when the source side caused the error, including the case where both sides fail on the same element.
- R12: A control byte with bit 7 = 0 but any other bit set is malformed. Such a command is rejected with an `err_o` pulse in the next cycle and emits nothing. `err_src_o` is 1 if the source byte is malformed.
- R13: `out_src_bytes_o` and `out_dst_bytes_o` equal the element sizes of the source and destination sides for every emitted element.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Block idle, command taken |
| src_base_i | input | 64 | Source start address |
| src_step_x_i | input | 32 | Source x stride, signed elements |
| src_step_y_i | input | 32 | Source y stride, signed elements |
| src_cnt_x_i | input | 16 | Source x count |
| src_cnt_y_i | input | 16 | Source y count |
| src_esize_i | input | 16 | Source element size in bytes |
| src_chk_i | input | 8 | Source limit-check control byte |
| dst_base_i | input | 64 | Destination start address |
| dst_step_x_i | input | 32 | Destination x stride, signed elements |
| dst_step_y_i | input | 32 | Destination y stride, signed elements |
| dst_cnt_x_i | input | 16 | Destination x count |
| dst_cnt_y_i | input | 16 | Destination y count |
| dst_esize_i | input | 16 | Destination element size in bytes |
| dst_chk_i | input | 8 | Destination limit-check control byte |
| wide_i | input | 1 | Take upper limit bits from the next register |
| lim_regs_i | input | NREG*32 | Limit register bank, register i at bits [32i+31:32i] |
| out_valid_o | output | 1 | Element available |
| out_ready_i | input | 1 | Element consumed |
| out_src_addr_o | output | 64 | Source element address |
| out_dst_addr_o | output | 64 | Destination element address |
| out_src_bytes_o | output | 16 | Source bytes for this element |
| out_dst_bytes_o | output | 16 | Destination bytes for this element |
| done_o | output | 1 | Command completed pulse |
| err_o | output | 1 | Command aborted or rejected pulse |
| err_src_o | output | 1 | Source side caused the last error |

## Verification
The assertions assume that a command is only offered together with stable fields in the cycle it is accepted, and that the limit bank is sampled only at that moment. The bench drives all command fields and limits before raising `cmd_valid_i` for a single cycle, and it changes limits only while the block is idle. Random commands keep counts small and strides in a narrow signed range. Limits are placed a few bytes around the start address, so passing, dropped and aborting elements all occur, while zero counts and malformed control bytes are mixed in at a low rate.

// File: rtl/stride2d_addr_gen.sv
module stride2d_addr_gen #(
  parameter int NREG = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [63:0]       src_base_i,
  input  logic [31:0]       src_step_x_i,
  input  logic [31:0]       src_step_y_i,
  input  logic [15:0]       src_cnt_x_i,
  input  logic [15:0]       src_cnt_y_i,
  input  logic [15:0]       src_esize_i,
  input  logic [7:0]        src_chk_i,
  input  logic [63:0]       dst_base_i,
  input  logic [31:0]       dst_step_x_i,
  input  logic [31:0]       dst_step_y_i,
  input  logic [15:0]       dst_cnt_x_i,
  input  logic [15:0]       dst_cnt_y_i,
  input  logic [15:0]       dst_esize_i,
  input  logic [7:0]        dst_chk_i,
  input  logic              wide_i,
  input  logic [NREG*32-1:0] lim_regs_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [63:0]       out_src_addr_o,
  output logic [63:0]       out_dst_addr_o,
  output logic [15:0]       out_src_bytes_o,
  output logic [15:0]       out_dst_bytes_o,
  output logic              done_o,
  output logic              err_o,
  output logic              err_src_o
);
  localparam int IW = $clog2(NREG);

  logic [63:0] c_base [2];
  logic [31:0] c_sx [2], c_sy [2];
  logic [15:0] c_cx [2], c_cy [2], c_esz [2];
  logic [7:0]  c_chk [2];
  logic [63:0] c_sxb [2], c_syb [2], c_lim [2];
  logic [31:0] c_tot [2];
  logic [1:0]  bad;

  logic        run_q, done_q, err_q, esrc_q;
  logic [31:0] rem_q;
  logic [63:0] cur_q [2], row_q [2], sxb_q [2], syb_q [2], lim_q [2];
  logic [15:0] ix_q [2], cx_q [2], esz_q [2];
  logic [1:0]  en_q, nn_q;

  logic [1:0]  oob, fatal;
  logic        accept, malformed, zero, adv;
  logic [31:0] tot_min;

  always_comb begin
    c_base[0] = src_base_i;   c_base[1] = dst_base_i;
    c_sx[0]   = src_step_x_i; c_sx[1]   = dst_step_x_i;
    c_sy[0]   = src_step_y_i; c_sy[1]   = dst_step_y_i;
    c_cx[0]   = src_cnt_x_i;  c_cx[1]   = dst_cnt_x_i;
    c_cy[0]   = src_cnt_y_i;  c_cy[1]   = dst_cnt_y_i;
    c_esz[0]  = src_esize_i;  c_esz[1]  = dst_esize_i;
    c_chk[0]  = src_chk_i;    c_chk[1]  = dst_chk_i;
    for (int s = 0; s < 2; s++) begin
      logic [IW-1:0] idx, idx1;
      idx  = c_chk[s][IW-1:0];
      idx1 = idx + 1'b1;
      c_sxb[s] = {{32{c_sx[s][31]}}, c_sx[s]} * {48'b0, c_esz[s]};
      c_syb[s] = {{32{c_sy[s][31]}}, c_sy[s]} * {48'b0, c_esz[s]};
      c_lim[s] = {wide_i ? lim_regs_i[{idx1, 5'b0} +: 32] : 32'b0,
                  lim_regs_i[{idx, 5'b0} +: 32]};
      c_tot[s] = {16'b0, c_cx[s]} * {16'b0, c_cy[s]};
      bad[s]   = !c_chk[s][7] && (c_chk[s][6:0] != 7'b0);
    end
  end

  assign malformed = |bad;
  assign zero      = (c_tot[0] == 32'b0) || (c_tot[1] == 32'b0);
  assign tot_min   = (c_tot[0] < c_tot[1]) ? c_tot[0] : c_tot[1];
  assign accept    = cmd_valid_i && !run_q;

  always_comb
    for (int s = 0; s < 2; s++) begin
      oob[s]   = en_q[s] && (cur_q[s] > lim_q[s]);
      fatal[s] = oob[s] && !nn_q[s];
    end

  assign out_valid_o     = run_q && !(|oob);
  assign adv             = run_q && !(|fatal) && ((|oob) || out_ready_i);
  assign cmd_ready_o     = !run_q;
  assign out_src_addr_o  = cur_q[0];
  assign out_dst_addr_o  = cur_q[1];
  assign out_src_bytes_o = esz_q[0];
  assign out_dst_bytes_o = esz_q[1];
  assign done_o          = done_q;
  assign err_o           = err_q;
  assign err_src_o       = esrc_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      esrc_q <= 1'b0;
      rem_q  <= 32'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (accept) begin
        if (malformed) begin
          err_q  <= 1'b1;
          esrc_q <= bad[0];
        end else if (zero) begin
          done_q <= 1'b1;
        end else begin
          run_q <= 1'b1;
          rem_q <= tot_min;
        end
      end else if (run_q) begin
        if (|fatal) begin
          err_q  <= 1'b1;
          esrc_q <= fatal[0];
          run_q  <= 1'b0;
        end else if (adv) begin
          rem_q <= rem_q - 32'd1;
          if (rem_q == 32'd1) begin
            run_q  <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end
    end

  always_ff @(posedge clk)
    for (int s = 0; s < 2; s++)
      if (accept) begin
        cur_q[s] <= c_base[s];
        row_q[s] <= c_base[s];
        ix_q[s]  <= 16'b0;
        cx_q[s]  <= c_cx[s];
        sxb_q[s] <= c_sxb[s];
        syb_q[s] <= c_syb[s];
        esz_q[s] <= c_esz[s];
        lim_q[s] <= c_lim[s];
        en_q[s]  <= c_chk[s][7];
        nn_q[s]  <= c_chk[s][6];
      end else if (adv) begin
        if (ix_q[s] == cx_q[s] - 16'd1) begin
          ix_q[s]  <= 16'b0;
          row_q[s] <= row_q[s] + syb_q[s];
          cur_q[s] <= row_q[s] + syb_q[s];
        end else begin
          ix_q[s]  <= ix_q[s] + 16'd1;
          cur_q[s] <= cur_q[s] + sxb_q[s];
        end
      end

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_src_addr_o) && $stable(out_dst_addr_o));

  assert_reject_R12: assert property (@(posedge clk) disable iff (!rst_n)
    accept && malformed |=> err_o && !out_valid_o && cmd_ready_o);

  assert_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !malformed && zero |=> done_o && !out_valid_o);

  assert_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o));

  assert_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !out_valid_o && cmd_ready_o);
endmodule

// File: tb/stride2d_addr_gen_tb.sv
module stride2d_addr_gen_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        cmd_valid = 1'b0, cmd_ready;
  logic [63:0] s_base, d_base;
  logic [31:0] s_sx, s_sy, d_sx, d_sy;
  logic [15:0] s_cx, s_cy, s_esz, d_cx, d_cy, d_esz;
  logic [7:0]  s_chk, d_chk;
  logic        wide;
  logic [31:0] lims [64];
  logic [2047:0] lim_flat;
  logic        ovalid, oready = 1'b0, done, err, esrc;
  logic [63:0] osa, oda;
  logic [15:0] osb, odb;

  always_comb for (int i = 0; i < 64; i++) lim_flat[i*32 +: 32] = lims[i];

  stride2d_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .src_base_i(s_base), .src_step_x_i(s_sx), .src_step_y_i(s_sy), .src_cnt_x_i(s_cx),
    .src_cnt_y_i(s_cy), .src_esize_i(s_esz), .src_chk_i(s_chk),
    .dst_base_i(d_base), .dst_step_x_i(d_sx), .dst_step_y_i(d_sy), .dst_cnt_x_i(d_cx),
    .dst_cnt_y_i(d_cy), .dst_esize_i(d_esz), .dst_chk_i(d_chk),
    .wide_i(wide), .lim_regs_i(lim_flat),
    .out_valid_o(ovalid), .out_ready_i(oready), .out_src_addr_o(osa), .out_dst_addr_o(oda),
    .out_src_bytes_o(osb), .out_dst_bytes_o(odb), .done_o(done), .err_o(err), .err_src_o(esrc));

  int checks = 0, errors = 0;
  logic [63:0] exp_s [64], exp_d [64];
  int exp_n;
  bit exp_err, exp_esrc;

  function automatic logic [63:0] eaddr(logic [63:0] b, logic [31:0] sx, logic [31:0] sy,
                                        int ix, int iy, logic [15:0] e);
    longint off;
    off = (longint'(ix) * longint'($signed(sx)) + longint'(iy) * longint'($signed(sy))) * longint'(e);
    return b + 64'(off);
  endfunction

  function automatic logic [63:0] lim_of(logic [7:0] chk);
    logic [5:0] i;
    i = chk[5:0];
    return {wide ? lims[6'(i + 6'd1)] : 32'b0, lims[i]};
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic build_exp();
    bit bs, bd;
    int ts, td, tot;
    bs = !s_chk[7] && s_chk[6:0] != 0;
    bd = !d_chk[7] && d_chk[6:0] != 0;
    exp_n = 0; exp_err = 0; exp_esrc = 0;
    if (bs || bd) begin exp_err = 1; exp_esrc = bs; return; end
    ts = int'(s_cx) * int'(s_cy);
    td = int'(d_cx) * int'(d_cy);
    tot = ts < td ? ts : td;
    for (int k = 0; k < tot; k++) begin
      logic [63:0] a, b;
      bit os, od;
      a = eaddr(s_base, s_sx, s_sy, k % int'(s_cx), k / int'(s_cx), s_esz);
      b = eaddr(d_base, d_sx, d_sy, k % int'(d_cx), k / int'(d_cx), d_esz);
      os = s_chk[7] && a > lim_of(s_chk);
      od = d_chk[7] && b > lim_of(d_chk);
      if (os && !s_chk[6]) begin exp_err = 1; exp_esrc = 1; return; end
      if (od && !d_chk[6]) begin exp_err = 1; exp_esrc = 0; return; end
      if (!(os || od)) begin exp_s[exp_n] = a; exp_d[exp_n] = b; exp_n++; end
    end
  endtask

  task automatic run_cmd(string tag);
    int k, cyc;
    bit fin, held;
    logic [63:0] hs, hd;
    build_exp();
    k = 0; cyc = 0; fin = 0; held = 0;
    @(negedge clk) cmd_valid = 1'b1;
    @(negedge clk) cmd_valid = 1'b0;
    while (!fin && cyc < 2000) begin
      oready = ($urandom % 4) != 0;
      if (held) chk(ovalid && osa == hs && oda == hd, "R6", "held element", osa, hs);
      held = 0;
      if (ovalid) begin
        if (oready) begin
          if (k < exp_n) begin
            chk(osa == exp_s[k] && oda == exp_d[k], tag, "element src/dst", {osa[31:0], oda[31:0]},
                {exp_s[k][31:0], exp_d[k][31:0]});
            chk(osb == s_esz && odb == d_esz, "R13", "bytes", {osb, odb}, {s_esz, d_esz});
          end else chk(0, tag, "extra element", osa, 64'h0);
          k++;
        end else begin held = 1; hs = osa; hd = oda; end
      end
      if (done || err) fin = 1;
      else begin @(negedge clk); cyc++; end
    end
    chk(fin, tag, "termination", 64'(cyc), 64'h0);
    chk(err == exp_err && done == !exp_err && k == exp_n && (!exp_err || esrc == exp_esrc),
        tag, "end err/done/esrc/count", {err, done, esrc, 32'(k)}, {exp_err, !exp_err, exp_esrc, 32'(exp_n)});
    oready = 1'b0;
    @(negedge clk);
    chk(!ovalid && !done && !err && cmd_ready, tag, "idle after end", {ovalid, done, err, cmd_ready}, 4'b0001);
  endtask

  task automatic plain(logic [63:0] sb, logic [31:0] ssx, logic [31:0] ssy, logic [15:0] scx,
                       logic [15:0] scy, logic [15:0] se, logic [63:0] db, logic [31:0] dsx,
                       logic [31:0] dsy, logic [15:0] dcx, logic [15:0] dcy, logic [15:0] de);
    s_base = sb; s_sx = ssx; s_sy = ssy; s_cx = scx; s_cy = scy; s_esz = se;
    d_base = db; d_sx = dsx; d_sy = dsy; d_cx = dcx; d_cy = dcy; d_esz = de;
    s_chk = 8'h00; d_chk = 8'h00; wide = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 64; i++) lims[i] = 32'h0;
    plain(0, 0, 0, 1, 1, 1, 0, 0, 0, 1, 1, 1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready && !ovalid && !done && !err, "R1", "reset state", {cmd_ready, ovalid, done, err}, 4'b1000);

    plain(64'h1000, 1, 4, 4, 2, 4, 64'h8000_0000_0000_0000, 2, 16, 4, 2, 2);
    run_cmd("R2");
    plain(64'h100, -32'sd1, -32'sd3, 3, 3, 8, 64'h40, -32'sd2, 5, 3, 3, 1);
    run_cmd("R3");
    plain(64'h100, 1, 1, 4, 0, 1, 64'h200, 1, 1, 2, 2, 1);
    run_cmd("R4");
    plain(64'h100, 1, 3, 3, 3, 2, 64'h900, 1, 2, 2, 2, 4);
    run_cmd("R5");

    plain(64'h2000, 1, 2, 2, 2, 4, 64'h3000, 1, 2, 2, 2, 4);
    s_chk = 8'h83; lims[3] = 32'h200C;
    run_cmd("R7");
    lims[3] = 32'h2005;
    run_cmd("R9");
    s_chk = 8'hC3;
    run_cmd("R10");
    s_chk = 8'h83; d_chk = 8'h84; lims[3] = 32'h1000; lims[4] = 32'h0;
    run_cmd("R11");

    plain(64'h0000_0007_0000_0010, 1, 2, 2, 2, 4, 64'h3000, 1, 2, 2, 2, 4);
    s_chk = 8'hBF; wide = 1'b1; lims[63] = 32'h10; lims[0] = 32'h7;
    run_cmd("R8");

    plain(64'h2000, 1, 2, 2, 2, 4, 64'h3000, 1, 2, 2, 2, 4);
    s_chk = 8'h05;
    run_cmd("R12");
    s_chk = 8'h00; d_chk = 8'h40;
    run_cmd("R12");

    for (int n = 0; n < 200; n++) begin
      logic [15:0] cnts [4];
      for (int j = 0; j < 4; j++) cnts[j] = ($urandom % 10 == 0) ? 16'd0 : 16'(1 + $urandom % 5);
      wide = $urandom % 3 == 0;
      plain({wide ? 32'h5 : 32'h0, 32'h1_0000 + $urandom % 32'h1000},
            32'($signed(int'($urandom % 17) - 8)), 32'($signed(int'($urandom % 17) - 8)),
            cnts[0], cnts[1], 16'(1 << ($urandom % 4)),
            {wide ? 32'h5 : 32'h0, 32'h4_0000 + $urandom % 32'h1000},
            32'($signed(int'($urandom % 17) - 8)), 32'($signed(int'($urandom % 17) - 8)),
            cnts[2], cnts[3], 16'(1 << ($urandom % 4)));
      wide = s_base[32];
      for (int side = 0; side < 2; side++) begin
        logic [7:0] c;
        logic [5:0] ix;
        int r;
        r = $urandom % 8;
        ix = 6'($urandom);
        if (r == 0) c = 8'h00;
        else if (r == 1) c = {1'b0, 7'(1 + $urandom % 127)};
        else c = {1'b1, 1'($urandom), ix};
        if (c[7]) begin
          lims[ix] = (side == 0 ? s_base[31:0] : d_base[31:0]) + 32'($urandom % 96) - 32'd32;
          lims[6'(ix + 6'd1)] = 32'h5;
        end
        if (side == 0) s_chk = c; else d_chk = c;
      end
      run_cmd("R2");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule